// File: doc/BRIEF.md
# Single-accumulator processor with one index register

This block is a small multi-cycle processor built around one 16-bit accumulator, one 9-bit index register and a 9-bit program counter. It runs programs from a 512-word internal memory. The same memory holds data, so a program can rewrite its own instructions. A host loads this memory through a write port and reads it back through a separate read port while the processor is stopped. The `run_en` input starts and stops execution.

Each instruction word carries an opcode, an addressing mode and a 9-bit address field. The operand address can be absolute, offset by the index register, or fetched from memory (one level of indirection). The instruction set covers:

- load, store, add, subtract and one-bit shifts;
- an unconditional jump and a sign-tested jump;
- extraction and insertion of an address field;
- index loading, storing, stepping and a loop-closing test;
- a subroutine call that leaves its return address in the first word of the callee.

A halt instruction stops fetching and raises `halted` until the next reset.

An instruction takes three cycles: fetch, decode and execute. An indirect operand adds a fourth cycle. Memory reads return data one cycle after the address is presented.

Top module: `acc_cpu`

## Requirements
- R1: While `rst_n` is low at a rising edge, the processor clears the program counter, accumulator and index register to zero and deasserts `halted`; memory contents are kept.
- R2: While `run_en` is low, the processor state does not change, `ld_we` writes `ld_data` to word `ld_addr`, and `rd_data` shows word `rd_addr` one cycle after the address is presented.
- R3: LOAD (opcode 1) copies the operand into the accumulator; STORE (2) writes the accumulator to the operand address; ADD (3) and SUB (4) add or subtract the operand modulo 2^16.
- R4: SHL (5) doubles the accumulator, dropping bit 15; SHR (6) shifts it right by one and keeps the sign bit.
- R5: JUMP (7) continues at the effective address; JGE (8) continues there only when accumulator bit 15 is 0, otherwise at the next word.
- R6: LDADR (9) sets the accumulator to bits 8:0 of the operand with the upper bits zero; STADR (10) rewrites bits 8:0 of the target word with accumulator bits 8:0 and keeps bits 15:9 of that word.
- R7: In indexed mode (mode 01) the effective address is the address field plus the index register, modulo 512.
- R8: JZI (11) jumps to the effective address when the index register is zero and otherwise increments it and falls through; LDI (12) loads the index register from operand bits 8:0; STI (13) stores the index register sign-extended to 16 bits; INCI (14) adds the raw 9-bit address field to the index register modulo 512.
- R9: In indirect mode (mode 10) the effective address is bits 8:0 of the word at the address field, so a data operand is the word at that pointer and an indirect JUMP continues at the pointer.
- R10: JSR (15) executed at word M writes M+1 (zero-extended) into the effective address F and continues at F+1.
- R11: HLT (opcode 0) asserts `halted` and leaves the program counter one past the HLT word; both stay unchanged until reset.
- R12: An instruction word holds the opcode in bits 15:11, the mode in bits 10:9 (00 absolute, 01 indexed, 10 indirect) and the address field in bits 8:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | High: the processor executes; low: it holds and the host port is active |
| ld_we | input | 1 | Host write strobe (used only while run_en is low) |
| ld_addr | input | 9 | Host write word address |
| ld_data | input | 16 | Host write data |
| rd_addr | input | 9 | Host read word address |
| rd_data | output | 16 | Host read data, one cycle after rd_addr |
| halted | output | 1 | High after a HLT instruction until reset |
| pc_out | output | 9 | Program counter |
| acc_out | output | 16 | Accumulator |
| ix_out | output | 9 | Index register |

## Verification
The assertions assume three things about the inputs. Reset is held for at least two cycles before the first check. The host does not write memory while `run_en` is high. Every program the processor runs ends in a HLT instruction.

The stimulus stays within these limits. Each run resets the processor, loads the program with `run_en` low, then raises `run_en` until `halted` is seen. The accumulator, index and program-counter checks use decoded instructions only. A sweep over many operand pairs covers the arithmetic, shift and sign-test rules. Loop and pointer programs over several data sets cover the index, indirect, self-modifying and subroutine rules.

// File: rtl/acc_cpu_pkg.sv
// Shared encodings for the accumulator processor.
// Assumes the instruction word is opcode | mode | address field, MSB first.
package acc_cpu_pkg;
    localparam int OP_W   = 5;
    localparam int MODE_W = 2;

    localparam logic [OP_W-1:0] OP_HLT   = 5'd0;
    localparam logic [OP_W-1:0] OP_LOAD  = 5'd1;
    localparam logic [OP_W-1:0] OP_STORE = 5'd2;
    localparam logic [OP_W-1:0] OP_ADD   = 5'd3;
    localparam logic [OP_W-1:0] OP_SUB   = 5'd4;
    localparam logic [OP_W-1:0] OP_SHL   = 5'd5;
    localparam logic [OP_W-1:0] OP_SHR   = 5'd6;
    localparam logic [OP_W-1:0] OP_JUMP  = 5'd7;
    localparam logic [OP_W-1:0] OP_JGE   = 5'd8;
    localparam logic [OP_W-1:0] OP_LDADR = 5'd9;
    localparam logic [OP_W-1:0] OP_STADR = 5'd10;
    localparam logic [OP_W-1:0] OP_JZI   = 5'd11;
    localparam logic [OP_W-1:0] OP_LDI   = 5'd12;
    localparam logic [OP_W-1:0] OP_STI   = 5'd13;
    localparam logic [OP_W-1:0] OP_INCI  = 5'd14;
    localparam logic [OP_W-1:0] OP_JSR   = 5'd15;

    localparam logic [MODE_W-1:0] MODE_ABS = 2'b00;
    localparam logic [MODE_W-1:0] MODE_IDX = 2'b01;
    localparam logic [MODE_W-1:0] MODE_IND = 2'b10;

    typedef enum logic [2:0] {
        ST_FETCH  = 3'd0,
        ST_DECODE = 3'd1,
        ST_INDIR  = 3'd2,
        ST_EXEC   = 3'd3,
        ST_HALT   = 3'd4
    } cpu_state_e;
endpackage

// File: rtl/acc_cpu_mem.sv
// Word memory with one read/write port for the processor and one read port
// for the host. Reads are registered (one cycle latency). The processor
// read port holds its output while re is low. No reset on contents.
module acc_cpu_mem #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata,
    input  logic [ADDR_W-1:0] host_raddr,
    output logic [DATA_W-1:0] host_rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] words [DEPTH];

    // Write port shared by processor and host (muxed above).
    always_ff @(posedge clk) begin
        if (we) begin
            words[waddr] <= wdata;
        end
    end

    // Processor read port, gated by re so a stalled sequencer keeps its data.
    always_ff @(posedge clk) begin
        if (re) begin
            rdata <= words[raddr];
        end
    end

    // Host read port.
    always_ff @(posedge clk) begin
        host_rdata <= words[host_raddr];
    end
endmodule

// File: rtl/acc_cpu_agen.sv
// Address generator used in the decode cycle. Produces the first memory
// address to read: the field itself for indirect mode, field + index for
// indexed mode, and the field for absolute mode (mode 11 acts as absolute).
module acc_cpu_agen
    import acc_cpu_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic [MODE_W-1:0] mode,
    input  logic [ADDR_W-1:0] field,
    input  logic [ADDR_W-1:0] ix,
    output logic [ADDR_W-1:0] first_addr,
    output logic              is_indirect
);
    // Select the offset and flag indirection.
    always_comb begin
        is_indirect = (mode == MODE_IND);
        if (mode == MODE_IDX) begin
            first_addr = field + ix;
        end else begin
            first_addr = field;
        end
    end
endmodule

// File: rtl/acc_cpu_exec.sv
// Execute-stage datapath. Combinational: given the decoded opcode, the
// current architectural state, the operand read at the effective address
// and the effective address, it forms next-state values and any write.
// Assumes pc already points past the executing instruction.
module acc_cpu_exec
    import acc_cpu_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 16
) (
    input  logic [OP_W-1:0]   op,
    input  logic [ADDR_W-1:0] k,
    input  logic [ADDR_W-1:0] ea,
    input  logic [DATA_W-1:0] opnd,
    input  logic [DATA_W-1:0] acc,
    input  logic [ADDR_W-1:0] ix,
    input  logic [ADDR_W-1:0] pc,
    output logic [DATA_W-1:0] acc_nxt,
    output logic [ADDR_W-1:0] ix_nxt,
    output logic [ADDR_W-1:0] pc_nxt,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data
);
    localparam int HI_W = DATA_W - ADDR_W;

    // Per-opcode next-state selection.
    always_comb begin
        acc_nxt = acc;
        ix_nxt  = ix;
        pc_nxt  = pc;
        wr_en   = 1'b0;
        wr_data = acc;
        case (op)
            OP_LOAD:  acc_nxt = opnd;
            OP_STORE: wr_en = 1'b1;
            OP_ADD:   acc_nxt = acc + opnd;
            OP_SUB:   acc_nxt = acc - opnd;
            OP_SHL:   acc_nxt = {acc[DATA_W-2:0], 1'b0};
            OP_SHR:   acc_nxt = {acc[DATA_W-1], acc[DATA_W-1:1]};
            OP_JUMP:  pc_nxt = ea;
            OP_JGE: begin
                if (!acc[DATA_W-1]) begin
                    pc_nxt = ea;
                end
            end
            OP_LDADR: acc_nxt = {{HI_W{1'b0}}, opnd[ADDR_W-1:0]};
            OP_STADR: begin
                wr_en   = 1'b1;
                wr_data = {opnd[DATA_W-1:ADDR_W], acc[ADDR_W-1:0]};
            end
            OP_JZI: begin
                if (ix == '0) begin
                    pc_nxt = ea;
                end else begin
                    ix_nxt = ix + 1'b1;
                end
            end
            OP_LDI:   ix_nxt = opnd[ADDR_W-1:0];
            OP_STI: begin
                wr_en   = 1'b1;
                wr_data = {{HI_W{ix[ADDR_W-1]}}, ix};
            end
            OP_INCI:  ix_nxt = ix + k;
            OP_JSR: begin
                wr_en   = 1'b1;
                wr_data = {{HI_W{1'b0}}, pc};
                pc_nxt  = ea + 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/acc_cpu.sv
// Multi-cycle single-accumulator processor with one index register.
// Sequence: FETCH (read at pc) -> DECODE (latch opcode/field, pc+1, form
// first address) -> [INDIR (pointer becomes effective address)] -> EXEC.
// Assumes the host only writes memory while run_en is low; all progress
// and all processor writes happen only while run_en is high.
module acc_cpu
    import acc_cpu_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           run_en,
    input  logic                           ld_we,
    input  logic [ADDR_W-1:0]              ld_addr,
    input  logic [OP_W+MODE_W+ADDR_W-1:0]  ld_data,
    input  logic [ADDR_W-1:0]              rd_addr,
    output logic [OP_W+MODE_W+ADDR_W-1:0]  rd_data,
    output logic                           halted,
    output logic [ADDR_W-1:0]              pc_out,
    output logic [OP_W+MODE_W+ADDR_W-1:0]  acc_out,
    output logic [ADDR_W-1:0]              ix_out
);
    localparam int DATA_W  = OP_W + MODE_W + ADDR_W;
    localparam int OP_LSB  = DATA_W - OP_W;
    localparam int MD_LSB  = ADDR_W;

    cpu_state_e        state_q;
    logic [ADDR_W-1:0] pc_q;
    logic [DATA_W-1:0] acc_q;
    logic [ADDR_W-1:0] ix_q;
    logic [OP_W-1:0]   op_q;
    logic [ADDR_W-1:0] k_q;
    logic [ADDR_W-1:0] ea_q;

    logic [DATA_W-1:0] mem_q;
    logic [ADDR_W-1:0] cpu_raddr;
    logic [ADDR_W-1:0] first_addr;
    logic              is_indirect;
    logic              exec_now;

    logic [DATA_W-1:0] acc_nxt;
    logic [ADDR_W-1:0] ix_nxt;
    logic [ADDR_W-1:0] pc_nxt;
    logic              ex_wr;
    logic [DATA_W-1:0] ex_wdata;

    logic              cpu_we;
    logic              m_we;
    logic [ADDR_W-1:0] m_waddr;
    logic [DATA_W-1:0] m_wdata;

    assign exec_now = (state_q == ST_EXEC);

    acc_cpu_agen #(.ADDR_W(ADDR_W)) u_agen (
        .mode        (mem_q[MD_LSB +: MODE_W]),
        .field       (mem_q[ADDR_W-1:0]),
        .ix          (ix_q),
        .first_addr  (first_addr),
        .is_indirect (is_indirect)
    );

    acc_cpu_exec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_exec (
        .op      (op_q),
        .k       (k_q),
        .ea      (ea_q),
        .opnd    (mem_q),
        .acc     (acc_q),
        .ix      (ix_q),
        .pc      (pc_q),
        .acc_nxt (acc_nxt),
        .ix_nxt  (ix_nxt),
        .pc_nxt  (pc_nxt),
        .wr_en   (ex_wr),
        .wr_data (ex_wdata)
    );

    // Memory read address for the cycle, by sequencer state.
    always_comb begin
        case (state_q)
            ST_FETCH:  cpu_raddr = pc_q;
            ST_DECODE: cpu_raddr = first_addr;
            ST_INDIR:  cpu_raddr = mem_q[ADDR_W-1:0];
            default:   cpu_raddr = pc_q;
        endcase
    end

    // Memory write source: processor while running, host while stopped.
    always_comb begin
        cpu_we = exec_now && run_en && ex_wr;
        if (run_en) begin
            m_we    = cpu_we;
            m_waddr = ea_q;
            m_wdata = ex_wdata;
        end else begin
            m_we    = ld_we;
            m_waddr = ld_addr;
            m_wdata = ld_data;
        end
    end

    acc_cpu_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk        (clk),
        .we         (m_we),
        .waddr      (m_waddr),
        .wdata      (m_wdata),
        .re         (run_en),
        .raddr      (cpu_raddr),
        .rdata      (mem_q),
        .host_raddr (rd_addr),
        .host_rdata (rd_data)
    );

    // Sequencer and architectural registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FETCH;
            pc_q    <= '0;
            acc_q   <= '0;
            ix_q    <= '0;
            op_q    <= OP_HLT;
            k_q     <= '0;
            ea_q    <= '0;
        end else if (run_en) begin
            case (state_q)
                ST_FETCH: state_q <= ST_DECODE;
                ST_DECODE: begin
                    op_q <= mem_q[OP_LSB +: OP_W];
                    k_q  <= mem_q[ADDR_W-1:0];
                    pc_q <= pc_q + 1'b1;
                    if (mem_q[OP_LSB +: OP_W] == OP_HLT) begin
                        state_q <= ST_HALT;
                    end else if (is_indirect) begin
                        state_q <= ST_INDIR;
                    end else begin
                        ea_q    <= first_addr;
                        state_q <= ST_EXEC;
                    end
                end
                ST_INDIR: begin
                    ea_q    <= mem_q[ADDR_W-1:0];
                    state_q <= ST_EXEC;
                end
                ST_EXEC: begin
                    acc_q   <= acc_nxt;
                    ix_q    <= ix_nxt;
                    pc_q    <= pc_nxt;
                    state_q <= ST_FETCH;
                end
                default: state_q <= ST_HALT;
            endcase
        end
    end

    assign halted  = (state_q == ST_HALT);
    assign pc_out  = pc_q;
    assign acc_out = acc_q;
    assign ix_out  = ix_q;
endmodule

// File: rtl/acc_cpu_chk.sv
// Property checker for acc_cpu, attached by bind. Assumes reset is held
// for at least two cycles and the host does not write while run_en is high.
module acc_cpu_chk
    import acc_cpu_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run_en,
    input logic              halted,
    input logic              exec_now,
    input logic [OP_W-1:0]   op,
    input logic [ADDR_W-1:0] ea,
    input logic [ADDR_W-1:0] pc,
    input logic [DATA_W-1:0] acc,
    input logic [ADDR_W-1:0] ix,
    input logic              cpu_we
);
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted && $stable(pc) && $stable(acc) && $stable(ix)); // R11

    AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> $stable(pc) && $stable(acc) && $stable(ix)); // R2

    AST_SHL_DOUBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_now && run_en && op == OP_SHL) |=> acc == {$past(acc[DATA_W-2:0]), 1'b0}); // R4

    AST_JGE_NEG_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_now && run_en && op == OP_JGE && acc[DATA_W-1]) |=> $stable(pc)); // R5

    AST_JZI_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_now && run_en && op == OP_JZI && ix != '0) |=> ix == $past(ix) + 1'b1); // R8

    AST_JSR_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_now && run_en && op == OP_JSR) |=> pc == $past(ea) + 1'b1); // R10

    AST_NO_WRITE_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |-> !cpu_we); // R2
endmodule

bind acc_cpu acc_cpu_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_en   (run_en),
    .halted   (halted),
    .exec_now (exec_now),
    .op       (op_q),
    .ea       (ea_q),
    .pc       (pc_q),
    .acc      (acc_q),
    .ix       (ix_q),
    .cpu_we   (cpu_we)
);

// File: tb/acc_cpu_tb.sv
`timescale 1ns/1ps
module acc_cpu_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b0;
    logic        ld_we = 1'b0;
    logic [8:0]  ld_addr = '0;
    logic [15:0] ld_data = '0;
    logic [8:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        halted;
    logic [8:0]  pc_out;
    logic [15:0] acc_out;
    logic [8:0]  ix_out;

    int vectors = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    acc_cpu u_dut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en),
        .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .halted(halted), .pc_out(pc_out), .acc_out(acc_out), .ix_out(ix_out)
    );

    // Word encoding from R12: opcode 15:11, mode 10:9, field 8:0.
    function automatic logic [15:0] enc(input int op, input int md, input int a);
        return {op[4:0], md[1:0], a[8:0]};
    endfunction

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic poke(input int a, input logic [15:0] d);
        ld_we = 1'b1; ld_addr = a[8:0]; ld_data = d;
        @(negedge clk);
        ld_we = 1'b0;
    endtask

    task automatic peek(input int a, output logic [15:0] d);
        rd_addr = a[8:0];
        @(negedge clk);
        d = rd_data;
    endtask

    task automatic do_reset();
        run_en = 1'b0; rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic run_wait(input string tag);
        int n = 0;
        run_en = 1'b1;
        while (!halted && n < 3000) begin
            @(negedge clk);
            n++;
        end
        run_en = 1'b0;
        check({tag, " halted"}, {15'd0, halted}, 16'd1);
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        logic [15:0] d, a, b, s_pc, s_acc;
        logic [15:0] av [4];
        logic [15:0] bv [4];
        @(negedge clk);
        do_reset();
        // R1: reset state
        check("R1 pc", {7'd0, pc_out}, 16'd0);
        check("R1 acc", acc_out, 16'd0);
        check("R1 ix", {7'd0, ix_out}, 16'd0);
        check("R1 halted", {15'd0, halted}, 16'd0);

        // Sweep: arithmetic, shifts, signed jump (R3 R4 R5).
        for (int i = 0; i < 32; i++) begin
            for (int j = 0; j < 8; j++) begin
                a = (i == 0) ? 16'h0000 : (i == 1) ? 16'h8000 : (i == 2) ? 16'h7FFF :
                    (i == 3) ? 16'hFFFF : 16'(i * 16'h0A37 + 16'h0111);
                b = (j == 0) ? 16'h0000 : (j == 1) ? 16'hFFFF : 16'(j * 16'h3C5B + 16'h0007);
                do_reset();
                poke(0, enc(1, 0, 100));  poke(1, enc(3, 0, 101));  poke(2, enc(2, 0, 102));
                poke(3, enc(1, 0, 100));  poke(4, enc(4, 0, 101));  poke(5, enc(2, 0, 103));
                poke(6, enc(1, 0, 100));  poke(7, enc(5, 0, 0));    poke(8, enc(2, 0, 104));
                poke(9, enc(1, 0, 100));  poke(10, enc(6, 0, 0));   poke(11, enc(2, 0, 105));
                poke(12, enc(1, 0, 100)); poke(13, enc(8, 0, 16));  poke(14, enc(1, 0, 106));
                poke(15, enc(0, 0, 0));   poke(16, enc(1, 0, 107)); poke(17, enc(0, 0, 0));
                poke(100, a); poke(101, b);
                for (int w = 102; w < 106; w++) poke(w, 16'hDEAD);
                poke(106, 16'h1111); poke(107, 16'h2222);
                run_wait("R11 sweep");
                peek(102, d); check("R3 add", d, a + b);
                peek(103, d); check("R3 sub", d, a - b);
                peek(104, d); check("R4 shl", d, {a[14:0], 1'b0});
                peek(105, d); check("R4 shr", d, {a[15], a[15:1]});
                check("R5 jge", acc_out, a[15] ? 16'h1111 : 16'h2222);
            end
        end

        // Indexed loop: C[i] = A[i] + B[i], index ops (R7 R8).
        for (int t = 0; t < 4; t++) begin
            do_reset();
            poke(0, enc(12, 0, 40)); poke(1, enc(11, 0, 7));
            poke(2, enc(1, 1, 53));  poke(3, enc(3, 1, 63));
            poke(4, enc(2, 1, 73));  poke(5, enc(7, 0, 1));
            poke(7, enc(13, 0, 41)); poke(8, enc(14, 0, 5));
            poke(9, enc(13, 0, 42)); poke(10, enc(14, 0, 506));
            poke(11, enc(13, 0, 43)); poke(12, enc(0, 0, 0));
            poke(40, 16'hFFFC);
            for (int e = 0; e < 4; e++) begin
                av[e] = 16'(t * 16'h1357 + e * 16'h0F01 + 16'h8001);
                bv[e] = 16'(t * 16'h2468 + e * 16'h7003 + 16'h0203);
                poke(50 + e, av[e]); poke(60 + e, bv[e]); poke(70 + e, 16'h0BAD);
            end
            run_wait("R11 loop");
            for (int e = 0; e < 4; e++) begin
                peek(70 + e, d); check("R7 indexed sum", d, av[e] + bv[e]);
            end
            peek(41, d); check("R8 sti zero", d, 16'h0000);
            peek(42, d); check("R8 inci", d, 16'h0005);
            peek(43, d); check("R8 sti sign", d, 16'hFFFF);
            check("R8 ix", {7'd0, ix_out}, 16'd511);
        end

        // Pointers, address fields, self-modifying code, subroutine (R6 R9 R10).
        do_reset();
        poke(0, enc(1, 2, 30));  poke(1, enc(2, 0, 80));
        poke(2, enc(9, 0, 31));  poke(3, enc(2, 0, 81));
        poke(4, enc(1, 0, 33));  poke(5, enc(10, 0, 8));
        poke(6, enc(10, 0, 34)); poke(7, enc(7, 0, 8));
        poke(8, enc(1, 0, 0));   poke(9, enc(2, 0, 82));
        poke(10, enc(15, 0, 20)); poke(11, enc(2, 0, 83));
        poke(12, enc(0, 0, 0));
        poke(20, 16'h0000); poke(21, enc(1, 0, 38));
        poke(22, enc(5, 0, 0)); poke(23, enc(7, 2, 20));
        poke(30, 16'h0020); poke(31, 16'hABCD); poke(32, 16'h1234);
        poke(33, 16'h0025); poke(34, 16'hFE00); poke(37, 16'h7777);
        poke(38, 16'h0042);
        // R2: a stall mid-program freezes the state.
        run_en = 1'b1;
        repeat (9) @(negedge clk);
        run_en = 1'b0;
        s_pc = {7'd0, pc_out}; s_acc = acc_out;
        repeat (10) @(negedge clk);
        check("R2 hold pc", {7'd0, pc_out}, s_pc);
        check("R2 hold acc", acc_out, s_acc);
        check("R9 acc mid", s_acc, 16'h1234);
        run_wait("R11 ptr");
        peek(80, d); check("R9 indirect load", d, 16'h1234);
        peek(81, d); check("R6 ldadr", d, 16'h01CD);
        peek(34, d); check("R6 stadr keeps upper", d, 16'hFE25);
        peek(8, d);  check("R6 patched instr", d, enc(1, 0, 37));
        peek(82, d); check("R6 self-modified load", d, 16'h7777);
        peek(20, d); check("R10 link", d, 16'd11);
        peek(83, d); check("R10 return and R9 indirect jump", d, 16'h0084);
        check("R11 pc past hlt", {7'd0, pc_out}, 16'd13);
        run_en = 1'b1;
        repeat (20) @(negedge clk);
        check("R11 still halted", {15'd0, halted}, 16'd1);
        check("R11 pc stays", {7'd0, pc_out}, 16'd13);
        run_en = 1'b0;
        // R1: reset clears state but keeps memory.
        do_reset();
        check("R1 acc after run", acc_out, 16'd0);
        check("R1 halt cleared", {15'd0, halted}, 16'd0);
        peek(83, d); check("R1 memory kept", d, 16'h0084);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule